// File: doc/BRIEF.md
# Random Tap Sequencer with Distribution Table

This block chooses, on every enabled tick of a control clock, which output of a tapped delay line should drive an edge. A five-bit shift register with internal XOR feedback produces a pseudorandom index. That index selects one word of a small table, and the word it selects is the tap code sent to the delay-line selector. The table is loaded beforehand with a distribution shape, such as a bell curve, two spikes or a sine histogram. The statistics of the injected timing error therefore follow whatever was stored, with no change to the logic.

The table is divided into banks of 32 words. A bank register chooses which shape is live, and the LFSR state chooses the word inside that bank. The word at LFSR index zero is never used, because the register never holds zero. When the block is disabled, the output rests on the reference tap, which is the middle of the delay line, and the LFSR freezes. The control clock rate sets how fast the phase steps arrive.

Top module: `jitter_tap_seq`

## Requirements
- R1: While rst_n is low, and on the first sample after release, tap_sel is 15, the bank register is 0 and the LFSR holds its seed (1).
- R2: Each clock with en high advances the LFSR one Galois step (mask 5'h14, taps x^5+x^3+1 family). The state sequence repeats every 31 enabled clocks, visits every nonzero value once per period and never holds zero.
- R3: On a clock with en high, tap_sel takes the table word at address {bank, lfsr}, where bank is bits [9:5] and the LFSR state is bits [4:0]. Both values are taken as they stood before that edge, so the output arrives one clock after the index.
- R4: On a clock with en low, tap_sel becomes 15 at that edge and the LFSR keeps its state, so the sequence resumes where it stopped.
- R5: A table write (wr_en, wr_addr, wr_data) at one edge is seen by any read at a later edge. A read of the same address at the same edge returns the old word.
- R6: bank_we at one edge loads bank_in into the bank register, and reads from the next edge on use the new bank.
- R7: Over any 31 consecutive enabled clocks with a fixed bank, the histogram of tap_sel equals the histogram of that bank's words at indices 1 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; each enabled edge is one phase step |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks output on the reference tap |
| bank_we | input | 1 | Load strobe for the bank register |
| bank_in | input | 5 | New bank number |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 10 | Table write address {bank, index} |
| wr_data | input | 5 | Tap code to store |
| tap_sel | output | 5 | Registered tap-select code |

## Verification
The LFSR state is not a port, so its period and the fact that it never reaches zero can only be seen through the table. The bench fills bank 0 with words equal to their own index, so that tap_sel shows the raw state over two full periods. The hardest case to reach is a write that lands on the very word being read in the same cycle. To produce it, the bench runs enabled while writing to addresses inside the live bank, and its reference model reads before it writes, so every same-edge collision is checked.

// File: rtl/tapseq_pkg.sv
package tapseq_pkg;
   localparam int DEF_CODE_W = 5;
   localparam int DEF_LFSR_W = 5;
   localparam int DEF_BANK_W = 5;
   localparam int DEF_REF_CODE = 15;
   // right-shift Galois mask: bits 4 and 2 receive the feedback
   localparam logic [DEF_LFSR_W-1:0] DEF_TAP_MASK = 5'h14;
   localparam logic [DEF_LFSR_W-1:0] DEF_SEED = 5'h01;
endpackage

// File: rtl/galois_lfsr.sv
module galois_lfsr #(
   parameter int W = 5,
   parameter logic [W-1:0] TAP_MASK = 5'h14,
   parameter logic [W-1:0] SEED = 5'h01
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state
);
   logic [W-1:0] q;
   logic [W-1:0] nxt;

   if (SEED == '0) begin : g_bad_seed
      $error("galois_lfsr: SEED must be nonzero");
   end
   if (TAP_MASK[W-1] != 1'b1) begin : g_bad_mask
      $error("galois_lfsr: TAP_MASK must set its top bit");
   end

   // XOR gates sit between stages; the output bit feeds back into each tap
   for (genvar i = 0; i < W; i++) begin : g_stage
      if (i == W - 1) begin : g_top
         assign nxt[i] = q[0] & TAP_MASK[i];
      end else begin : g_mid
         assign nxt[i] = q[i+1] ^ (q[0] & TAP_MASK[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= SEED;
      end else if (q == '0) begin
         q <= SEED;
      end else if (step) begin
         q <= nxt;
      end
   end

   assign state = q;
endmodule

// File: rtl/dist_table.sv
module dist_table #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 5
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // combinational read; the caller registers it, so a same-edge write is not seen
   assign rdata = mem[raddr];
endmodule

// File: rtl/jitter_tap_seq.sv
module jitter_tap_seq
   import tapseq_pkg::*;
#(
   parameter int CODE_W = DEF_CODE_W,
   parameter int LFSR_W = DEF_LFSR_W,
   parameter int BANK_W = DEF_BANK_W,
   parameter int REF_CODE = DEF_REF_CODE,
   parameter logic [LFSR_W-1:0] TAP_MASK = DEF_TAP_MASK,
   parameter logic [LFSR_W-1:0] SEED = DEF_SEED
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      bank_we,
   input  logic [BANK_W-1:0]         bank_in,
   input  logic                      wr_en,
   input  logic [BANK_W+LFSR_W-1:0]  wr_addr,
   input  logic [CODE_W-1:0]         wr_data,
   output logic [CODE_W-1:0]         tap_sel
);
   localparam int ADDR_W = BANK_W + LFSR_W;
   localparam logic [CODE_W-1:0] REF_L = CODE_W'(REF_CODE);

   if (REF_CODE < 0 || REF_CODE >= (1 << CODE_W)) begin : g_bad_ref
      $error("jitter_tap_seq: REF_CODE does not fit CODE_W");
   end
   if (ADDR_W > 12) begin : g_bad_depth
      $error("jitter_tap_seq: table deeper than 4096 words");
   end

   logic [LFSR_W-1:0] lfsr_q;
   logic [BANK_W-1:0] bank_q;
   logic [CODE_W-1:0] rd_word;
   logic [CODE_W-1:0] tap_q;

   galois_lfsr #(
      .W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step(en), .state(lfsr_q)
   );

   dist_table #(
      .ADDR_W(ADDR_W), .DATA_W(CODE_W)
   ) u_table (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
      .raddr({bank_q, lfsr_q}), .rdata(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (bank_we) begin
         bank_q <= bank_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= REF_L;
      end else begin
         tap_q <= en ? rd_word : REF_L;
      end
   end

   assign tap_sel = tap_q;
endmodule

// File: rtl/tapseq_checker.sv
module tapseq_checker #(
   parameter int CODE_W = 5,
   parameter int LFSR_W = 5,
   parameter int BANK_W = 5,
   parameter int REF_CODE = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              bank_we,
   input logic [BANK_W-1:0] bank_in,
   input logic [BANK_W-1:0] bank_q,
   input logic [LFSR_W-1:0] lfsr_q,
   input logic [CODE_W-1:0] tap_sel
);
   localparam logic [CODE_W-1:0] REF_L = CODE_W'(REF_CODE);

   assert_park_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> tap_sel == REF_L);

   assert_hold_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(lfsr_q));

   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> lfsr_q != $past(lfsr_q));

   assert_never_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

   assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> bank_q == $past(bank_in));
endmodule

bind jitter_tap_seq tapseq_checker #(
   .CODE_W(CODE_W), .LFSR_W(LFSR_W), .BANK_W(BANK_W), .REF_CODE(REF_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .bank_we(bank_we), .bank_in(bank_in),
   .bank_q(bank_q), .lfsr_q(lfsr_q), .tap_sel(tap_sel)
);

// File: tb/tb_jitter_tap_seq.sv
module tb_jitter_tap_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 50000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       bank_we = 1'b0;
   logic [4:0] bank_in = '0;
   logic       wr_en = 1'b0;
   logic [9:0] wr_addr = '0;
   logic [4:0] wr_data = '0;
   logic [4:0] tap_sel;

   int checks = 0;
   int failures = 0;
   string tag = "R3";
   bit done = 1'b0;

   // reference model state
   int tbl [1024];
   int m_state = 1;
   int m_bank = 0;
   int m_out = 15;
   bit m_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jitter_tap_seq dut (
      .clk(clk), .rst_n(rst_n), .en(en), .bank_we(bank_we), .bank_in(bank_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tap_sel(tap_sel)
   );

   function automatic int next_state(int s);
      int r;
      r = s / 2;
      if (s % 2 == 1) r = r ^ 'h14;
      return r;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 1; m_bank = 0; m_out = 15;
      end else begin
         m_valid = 1'b1;
         if (en) begin
            m_out = tbl[m_bank*32 + m_state];
            m_state = next_state(m_state);
         end else begin
            m_out = 15;
         end
         if (bank_we) m_bank = int'(bank_in);
         if (wr_en) tbl[int'(wr_addr)] = int'(wr_data);
      end
   end

   always @(negedge clk) begin
      if (rst_n && m_valid && !done) check(tag, int'(tap_sel), m_out);
   end

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int pattern(int a);
      if (a < 32) return a;            // identity bank exposes the LFSR state
      return (a * 13 + (a / 32) * 7) % 32;
   endfunction

   initial begin
      int rec [62];
      int hist_act [32];
      int hist_exp [32];
      bit seen [32];
      for (int i = 0; i < 1024; i++) tbl[i] = 0;
      repeat (3) tick();
      // R1: reset values
      check("R1", int'(tap_sel), 15);
      rst_n = 1'b1;
      tick();
      check("R1", int'(tap_sel), 15);

      // load every word with en low
      tag = "R4";
      for (int a = 0; a < 1024; a++) begin
         wr_en = 1'b1; wr_addr = 10'(a); wr_data = 5'(pattern(a));
         tick();
      end
      wr_en = 1'b0;
      tick();

      // R2: period 31 over two periods with the identity bank
      tag = "R3";
      en = 1'b1;
      for (int i = 0; i < 62; i++) begin
         tick();
         rec[i] = int'(tap_sel);
      end
      check("R2", rec[0], 1);  // first read uses the seed
      for (int i = 0; i < 32; i++) seen[i] = 1'b0;
      for (int i = 0; i < 31; i++) begin
         check("R2", int'(rec[i] == 0), 0);
         check("R2", int'(seen[rec[i]]), 0);
         seen[rec[i]] = 1'b1;
         check("R2", rec[i + 31], rec[i]);
      end

      // R4: pause, then resume where it stopped
      tag = "R4";
      en = 1'b0;
      repeat (5) tick();
      check("R4", int'(tap_sel), 15);
      en = 1'b1;
      tag = "R3";
      tick();
      check("R4", int'(tap_sel), next_state(rec[61]) == 0 ? -1 : next_state(rec[61]));

      // R6 + R7: switch to bank 3 and build the histogram over 31 steps
      tag = "R6";
      en = 1'b0; bank_we = 1'b1; bank_in = 5'd3;
      tick();
      bank_we = 1'b0; en = 1'b1;
      for (int i = 0; i < 32; i++) begin hist_act[i] = 0; hist_exp[i] = 0; end
      for (int k = 1; k < 32; k++) hist_exp[tbl[3*32 + k]]++;
      for (int i = 0; i < 31; i++) begin
         tick();
         hist_act[int'(tap_sel)]++;
      end
      for (int v = 0; v < 32; v++) check("R7", hist_act[v], hist_exp[v]);

      // R5: writes into the live bank while reading, including same-edge hits
      tag = "R5";
      for (int i = 0; i < 200; i++) begin
         wr_en = 1'b1;
         wr_addr = {5'd3, 5'($urandom_range(0, 31))};
         wr_data = 5'($urandom_range(0, 31));
         tick();
      end
      wr_en = 1'b0;
      repeat (40) tick();

      // R6: bank change while running
      bank_we = 1'b1; bank_in = 5'd17;
      tick();
      bank_we = 1'b0;
      repeat (40) tick();
      en = 1'b0;
      tick();
      check("R4", int'(tap_sel), 15);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      failures++;
      done = 1'b1;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule